// File: doc/BRIEF.md
# I2C Random-Access Memory Transfer Sequencer

This block sits above a byte-level I2C master engine and carries out complete reads and writes at a chosen location inside an attached memory device. A single request supplies the following:

- a 7-bit device address;
- a 16-bit internal location, sent as either one or two bytes;
- a byte length of up to 65535;
- a direction;
- a timeout in clock ticks.

Payload bytes flow through a valid/ready byte stream in each direction. The sequencer programs the engine one segment at a time and watches its status flags. It finishes with a one-cycle completion pulse that carries a result code.

A write sends the location bytes in a reload segment. The payload then continues with no new START. A read first writes the location in a software-end segment. When that segment completes, the read issues a repeated START with the read direction. In both directions the payload is cut into segments of at most 255 bytes. Every segment except the last continues by reload, and the last ends with an automatic STOP. The engine reports the following flags to the sequencer:

- transmit-ready;
- receive-ready;
- reload-pause;
- soft-end-pause;
- stop-seen;
- no-acknowledge;
- bus-busy.

Top module: `i2c_mem_seq`

## Requirements
- R1: A write request starts with one engine configuration that has START set, the write direction, the reload mode (engMode 1) and a count of 2 for a two-byte location or 1 for a one-byte location. The upper location byte goes out before the lower one, and a one-byte location sends only the lower byte. Each byte is written only while the engine shows transmit-ready.
- R2: Payload segments have a count of min(remaining, 255). A segment uses reload (engMode 1) while more than 255 bytes remain, and automatic end (engMode 2) otherwise. Write segments never set START. A further segment is configured only after the engine reports reload-pause.
- R3: A read request writes the location in a segment that uses software end (engMode 0). After the engine reports soft-end-pause, the first payload segment is configured with START and the read direction. Any later read segments carry no START.
- R4: Read bytes are offered on rdValid while the engine shows receive-ready. A byte is taken from the engine (engRxAck) only on a rdValid and rdReady handshake. Bytes are delivered in the order received.
- R5: After the last payload byte the sequencer waits for stop-seen. It then pulses engClrStop and reports result 0 (success) on the next cycle.
- R6: A zero-length request causes no engine activity. It is answered with result 1 (invalid) on the cycle after the request.
- R7: A request that arrives while a transfer is running gives a reqReject pulse on the next cycle. It does not disturb the running transfer.
- R8: No engine configuration happens while engBusy is high. If the bus stays busy for BUSY_TICKS cycles, the request ends with result 2 (busy) and no engine configuration.
- R9: On no-acknowledge during any wait, the sequencer waits for stop-seen. It then pulses engClrNack, engClrStop and engFlush together and reports result 3 (no acknowledge).
- R10: The timeout counts clock ticks from request acceptance, and result 4 (timeout) is reported once it runs out. A value of all ones disables the timeout. A value of zero fails at the first wait after the bus is found idle.
- R11: After reset the block is idle: no completion, reject, handshake or engine strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe, one cycle |
| reqDev | input | 7 | Device address |
| reqMemAddr | input | 16 | Internal location |
| reqAddr16 | input | 1 | 1: two-byte location, 0: one byte |
| reqRead | input | 1 | 1: read, 0: write |
| reqLen | input | 16 | Payload byte count |
| reqTimeout | input | 32 | Timeout in ticks, all ones disables |
| reqReject | output | 1 | Request refused while running |
| doneValid | output | 1 | Completion pulse |
| doneCode | output | 3 | Result: 0 ok, 1 invalid, 2 busy, 3 no ack, 4 timeout |
| wrValid | input | 1 | Write payload byte available |
| wrData | input | 8 | Write payload byte |
| wrReady | output | 1 | Write payload byte taken |
| rdValid | output | 1 | Read payload byte available |
| rdData | output | 8 | Read payload byte |
| rdReady | input | 1 | Read payload byte accepted |
| engBusy | input | 1 | Bus busy flag |
| engTxis | input | 1 | Engine ready for a transmit byte |
| engRxne | input | 1 | Engine holds a received byte |
| engTcr | input | 1 | Reload pause reached |
| engTc | input | 1 | Software-end pause reached |
| engStopf | input | 1 | STOP seen |
| engNackf | input | 1 | No acknowledge seen |
| engRxData | input | 8 | Received byte from engine |
| engCfg | output | 1 | Segment configuration strobe |
| engStart | output | 1 | Issue START with this segment |
| engRead | output | 1 | Segment direction is read |
| engDev | output | 7 | Device address for the segment |
| engCount | output | 8 | Segment byte count |
| engMode | output | 2 | 0 software end, 1 reload, 2 automatic end |
| engTxWr | output | 1 | Transmit byte write strobe |
| engTxData | output | 8 | Transmit byte |
| engRxAck | output | 1 | Received byte consumed |
| engClrStop | output | 1 | Clear STOP flag |
| engClrNack | output | 1 | Clear no-acknowledge flag |
| engFlush | output | 1 | Flush engine transmit data |

## Verification
The assertions assume that the engine behaves like a real master. Transmit-ready and receive-ready appear only while a segment still has bytes to move. No-acknowledge is always followed by stop-seen. The engine model in the bench follows these rules by construction: it raises each flag from its own segment counter and sets stop-seen in the same cycle as a no-acknowledge. A stall input holds the model's data flags low, so the timeout paths can be reached without breaking those rules.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

  typedef enum logic [1:0] {
    SEG_SOFT   = 2'd0,
    SEG_RELOAD = 2'd1,
    SEG_AUTO   = 2'd2
  } segMode_t;

  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_INVAL   = 3'd1,
    RES_BUSY    = 3'd2,
    RES_NACK    = 3'd3,
    RES_TIMEOUT = 3'd4
  } result_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic loadSeg;
    logic byteDone;
    logic segIssued;
  } dpCmd_t;

endpackage

// File: rtl/i2c_mem_dp.sv
module i2c_mem_dp
  import i2c_mem_pkg::*;
#(
  parameter int DEV_W      = 7,
  parameter int LEN_W      = 16,
  parameter int TO_W       = 32,
  parameter int SEG_MAX    = 255,
  parameter int BUSY_TICKS = 2500000
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCmd_t             cmd,
  input  logic [DEV_W-1:0]   reqDev,
  input  logic [15:0]        reqMemAddr,
  input  logic               reqAddr16,
  input  logic               reqRead,
  input  logic [LEN_W-1:0]   reqLen,
  input  logic [TO_W-1:0]    reqTimeout,
  output logic [DEV_W-1:0]   dev,
  output logic [7:0]         memHi,
  output logic [7:0]         memLo,
  output logic               addr16,
  output logic               isRead,
  output logic [$clog2(SEG_MAX+1)-1:0] segCnt,
  output logic               lastSeg,
  output logic               firstSeg,
  output logic               segOne,
  output logic               remOne,
  output logic               toExpired,
  output logic               busyExpired
);

  localparam int SEG_W  = $clog2(SEG_MAX + 1);
  localparam int BUSY_W = $clog2(BUSY_TICKS + 1);

  logic [LEN_W-1:0]  remCnt;
  logic [TO_W-1:0]   toLim;
  logic [TO_W-1:0]   toCnt;
  logic [BUSY_W-1:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dev      <= '0;
      memHi    <= '0;
      memLo    <= '0;
      addr16   <= 1'b0;
      isRead   <= 1'b0;
      remCnt   <= '0;
      segCnt   <= '0;
      lastSeg  <= 1'b0;
      firstSeg <= 1'b0;
      toLim    <= '0;
      toCnt    <= '0;
      busyCnt  <= '0;
    end else if (cmd.latchReq) begin
      dev      <= reqDev;
      memHi    <= reqMemAddr[15:8];
      memLo    <= reqMemAddr[7:0];
      addr16   <= reqAddr16;
      isRead   <= reqRead;
      remCnt   <= reqLen;
      segCnt   <= '0;
      lastSeg  <= 1'b0;
      firstSeg <= 1'b1;
      toLim    <= reqTimeout;
      toCnt    <= '0;
      busyCnt  <= '0;
    end else begin
      if (toCnt != '1) toCnt <= toCnt + 1'b1;
      if (busyCnt != BUSY_W'(BUSY_TICKS)) busyCnt <= busyCnt + 1'b1;
      if (cmd.loadSeg) begin
        if (remCnt > LEN_W'(SEG_MAX)) begin
          segCnt  <= SEG_W'(SEG_MAX);
          lastSeg <= 1'b0;
        end else begin
          segCnt  <= SEG_W'(remCnt);
          lastSeg <= 1'b1;
        end
      end else if (cmd.byteDone) begin
        remCnt <= remCnt - 1'b1;
        segCnt <= segCnt - 1'b1;
      end
      if (cmd.segIssued) firstSeg <= 1'b0;
    end
  end

  assign segOne      = (segCnt == SEG_W'(1));
  assign remOne      = (remCnt == LEN_W'(1));
  assign toExpired   = (toLim != '1) && (toCnt >= toLim);
  assign busyExpired = (busyCnt >= BUSY_W'(BUSY_TICKS));

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    cmd.byteDone |-> (remCnt != '0) && (segCnt != '0)); // R2

  AST_SEG_WITHIN_REM: assert property (@(posedge clk) disable iff (!rstN)
    cmd.byteDone |-> (LEN_W'(segCnt) <= remCnt)); // R2

endmodule

// File: rtl/i2c_mem_ctl.sv
module i2c_mem_ctl
  import i2c_mem_pkg::*;
#(
  parameter int DEV_W   = 7,
  parameter int SEG_MAX = 255
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqLenZero,
  output logic             reqReject,
  output logic             doneValid,
  output logic [2:0]       doneCode,
  input  logic             wrValid,
  input  logic [7:0]       wrData,
  output logic             wrReady,
  output logic             rdValid,
  input  logic             rdReady,
  input  logic             engBusy,
  input  logic             engTxis,
  input  logic             engRxne,
  input  logic             engTcr,
  input  logic             engTc,
  input  logic             engStopf,
  input  logic             engNackf,
  output logic             engCfg,
  output logic             engStart,
  output logic             engRead,
  output logic [$clog2(SEG_MAX+1)-1:0] engCount,
  output logic [1:0]       engMode,
  output logic             engTxWr,
  output logic [7:0]       engTxData,
  output logic             engRxAck,
  output logic             engClrStop,
  output logic             engClrNack,
  output logic             engFlush,
  output dpCmd_t           cmd,
  input  logic [7:0]       memHi,
  input  logic [7:0]       memLo,
  input  logic             addr16,
  input  logic             isRead,
  input  logic [$clog2(SEG_MAX+1)-1:0] segCnt,
  input  logic             lastSeg,
  input  logic             firstSeg,
  input  logic             segOne,
  input  logic             remOne,
  input  logic             toExpired,
  input  logic             busyExpired
);

  localparam int SEG_W = $clog2(SEG_MAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_WAIT_BUS, S_CFG_ADDR, S_ADDR_HI, S_ADDR_LO, S_WAIT_ADDR,
    S_CFG_DATA, S_WR_DATA, S_RD_DATA, S_WAIT_TCR, S_WAIT_STOP, S_NACK_STOP
  } state_t;

  state_t  state, nextState;
  logic    finish;
  result_t finCode;

  always_comb begin
    nextState  = state;
    finish     = 1'b0;
    finCode    = RES_OK;
    cmd        = '0;
    engCfg     = 1'b0;
    engStart   = 1'b0;
    engRead    = 1'b0;
    engCount   = '0;
    engMode    = SEG_SOFT;
    engTxWr    = 1'b0;
    engTxData  = '0;
    engRxAck   = 1'b0;
    engClrStop = 1'b0;
    engClrNack = 1'b0;
    engFlush   = 1'b0;
    wrReady    = 1'b0;
    rdValid    = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          if (reqLenZero) begin
            finish  = 1'b1;
            finCode = RES_INVAL;
          end else begin
            cmd.latchReq = 1'b1;
            nextState    = S_WAIT_BUS;
          end
        end
      end
      S_WAIT_BUS: begin
        if (!engBusy) nextState = S_CFG_ADDR;
        else if (busyExpired) begin
          finish  = 1'b1;
          finCode = RES_BUSY;
        end
      end
      S_CFG_ADDR: begin
        engCfg    = 1'b1;
        engStart  = 1'b1;
        engCount  = addr16 ? SEG_W'(2) : SEG_W'(1);
        engMode   = isRead ? SEG_SOFT : SEG_RELOAD;
        nextState = addr16 ? S_ADDR_HI : S_ADDR_LO;
      end
      S_ADDR_HI, S_ADDR_LO: begin
        if (engNackf) nextState = S_NACK_STOP;
        else if (toExpired) begin
          finish  = 1'b1;
          finCode = RES_TIMEOUT;
        end else if (engTxis) begin
          engTxWr   = 1'b1;
          engTxData = (state == S_ADDR_HI) ? memHi : memLo;
          nextState = (state == S_ADDR_HI) ? S_ADDR_LO : S_WAIT_ADDR;
        end
      end
      S_WAIT_ADDR: begin
        if (engNackf) nextState = S_NACK_STOP;
        else if (toExpired) begin
          finish  = 1'b1;
          finCode = RES_TIMEOUT;
        end else if (isRead ? engTc : engTcr) begin
          cmd.loadSeg = 1'b1;
          nextState   = S_CFG_DATA;
        end
      end
      S_CFG_DATA: begin
        engCfg        = 1'b1;
        engStart      = isRead && firstSeg;
        engRead       = isRead;
        engCount      = segCnt;
        engMode       = lastSeg ? SEG_AUTO : SEG_RELOAD;
        cmd.segIssued = 1'b1;
        nextState     = isRead ? S_RD_DATA : S_WR_DATA;
      end
      S_WR_DATA: begin
        if (engNackf) nextState = S_NACK_STOP;
        else if (toExpired) begin
          finish  = 1'b1;
          finCode = RES_TIMEOUT;
        end else if (engTxis) begin
          wrReady = 1'b1;
          if (wrValid) begin
            engTxWr      = 1'b1;
            engTxData    = wrData;
            cmd.byteDone = 1'b1;
            if (segOne) nextState = remOne ? S_WAIT_STOP : S_WAIT_TCR;
          end
        end
      end
      S_RD_DATA: begin
        if (engNackf) nextState = S_NACK_STOP;
        else if (toExpired) begin
          finish  = 1'b1;
          finCode = RES_TIMEOUT;
        end else begin
          rdValid = engRxne;
          if (engRxne && rdReady) begin
            engRxAck     = 1'b1;
            cmd.byteDone = 1'b1;
            if (segOne) nextState = remOne ? S_WAIT_STOP : S_WAIT_TCR;
          end
        end
      end
      S_WAIT_TCR: begin
        if (engNackf) nextState = S_NACK_STOP;
        else if (toExpired) begin
          finish  = 1'b1;
          finCode = RES_TIMEOUT;
        end else if (engTcr) begin
          cmd.loadSeg = 1'b1;
          nextState   = S_CFG_DATA;
        end
      end
      S_WAIT_STOP: begin
        if (engNackf) nextState = S_NACK_STOP;
        else if (toExpired) begin
          finish  = 1'b1;
          finCode = RES_TIMEOUT;
        end else if (engStopf) begin
          engClrStop = 1'b1;
          finish     = 1'b1;
          finCode    = RES_OK;
        end
      end
      S_NACK_STOP: begin
        if (engStopf) begin
          engClrNack = 1'b1;
          engClrStop = 1'b1;
          engFlush   = 1'b1;
          finish     = 1'b1;
          finCode    = RES_NACK;
        end else if (toExpired) begin
          finish  = 1'b1;
          finCode = RES_TIMEOUT;
        end
      end
      default: nextState = S_IDLE;
    endcase
    if (finish) nextState = S_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      doneValid <= 1'b0;
      doneCode  <= RES_OK;
      reqReject <= 1'b0;
    end else begin
      state     <= nextState;
      doneValid <= finish;
      doneCode  <= finCode;
      reqReject <= reqValid && (state != S_IDLE);
    end
  end

  AST_TXWR_WITH_TXIS: assert property (@(posedge clk) disable iff (!rstN)
    engTxWr |-> engTxis); // R1

  AST_CFG_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    engCfg |-> (engCount != '0) && (engCount <= SEG_W'(SEG_MAX))); // R2

  AST_RXACK_WITH_RXNE: assert property (@(posedge clk) disable iff (!rstN)
    engRxAck |-> engRxne && rdReady); // R4

  AST_OK_AFTER_STOP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneCode == RES_OK) |-> $past(engClrStop)); // R5

  AST_INVAL_NO_CFG: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneCode == RES_INVAL) |-> !$past(engCfg)); // R6

  AST_REJECT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqReject |-> $past(reqValid)); // R7

  AST_CFG_NOT_BUSY_START: assert property (@(posedge clk) disable iff (!rstN)
    (engCfg && engStart && !engRead) |-> !$past(engBusy)); // R8

  AST_NACK_CLEAR_AFTER_STOP: assert property (@(posedge clk) disable iff (!rstN)
    engClrNack |-> engStopf && engNackf); // R9

endmodule

// File: rtl/i2c_mem_seq.sv
module i2c_mem_seq
  import i2c_mem_pkg::*;
#(
  parameter int DEV_W      = 7,
  parameter int LEN_W      = 16,
  parameter int TO_W       = 32,
  parameter int SEG_MAX    = 255,
  parameter int BUSY_TICKS = 2500000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [DEV_W-1:0]     reqDev,
  input  logic [15:0]          reqMemAddr,
  input  logic                 reqAddr16,
  input  logic                 reqRead,
  input  logic [LEN_W-1:0]     reqLen,
  input  logic [TO_W-1:0]      reqTimeout,
  output logic                 reqReject,
  output logic                 doneValid,
  output logic [2:0]           doneCode,
  input  logic                 wrValid,
  input  logic [7:0]           wrData,
  output logic                 wrReady,
  output logic                 rdValid,
  output logic [7:0]           rdData,
  input  logic                 rdReady,
  input  logic                 engBusy,
  input  logic                 engTxis,
  input  logic                 engRxne,
  input  logic                 engTcr,
  input  logic                 engTc,
  input  logic                 engStopf,
  input  logic                 engNackf,
  input  logic [7:0]           engRxData,
  output logic                 engCfg,
  output logic                 engStart,
  output logic                 engRead,
  output logic [DEV_W-1:0]     engDev,
  output logic [$clog2(SEG_MAX+1)-1:0] engCount,
  output logic [1:0]           engMode,
  output logic                 engTxWr,
  output logic [7:0]           engTxData,
  output logic                 engRxAck,
  output logic                 engClrStop,
  output logic                 engClrNack,
  output logic                 engFlush
);

  localparam int SEG_W = $clog2(SEG_MAX + 1);

  dpCmd_t           cmd;
  logic [7:0]       memHi, memLo;
  logic             addr16, isRead, lastSeg, firstSeg, segOne, remOne;
  logic             toExpired, busyExpired;
  logic [SEG_W-1:0] segCnt;

  assign rdData = engRxData;

  i2c_mem_dp #(
    .DEV_W(DEV_W), .LEN_W(LEN_W), .TO_W(TO_W),
    .SEG_MAX(SEG_MAX), .BUSY_TICKS(BUSY_TICKS)
  ) dpInst (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .reqDev(reqDev), .reqMemAddr(reqMemAddr), .reqAddr16(reqAddr16),
    .reqRead(reqRead), .reqLen(reqLen), .reqTimeout(reqTimeout),
    .dev(engDev), .memHi(memHi), .memLo(memLo), .addr16(addr16),
    .isRead(isRead), .segCnt(segCnt), .lastSeg(lastSeg),
    .firstSeg(firstSeg), .segOne(segOne), .remOne(remOne),
    .toExpired(toExpired), .busyExpired(busyExpired)
  );

  i2c_mem_ctl #(.DEV_W(DEV_W), .SEG_MAX(SEG_MAX)) ctlInst (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqLenZero(reqLen == '0),
    .reqReject(reqReject), .doneValid(doneValid), .doneCode(doneCode),
    .wrValid(wrValid), .wrData(wrData), .wrReady(wrReady),
    .rdValid(rdValid), .rdReady(rdReady),
    .engBusy(engBusy), .engTxis(engTxis), .engRxne(engRxne),
    .engTcr(engTcr), .engTc(engTc), .engStopf(engStopf), .engNackf(engNackf),
    .engCfg(engCfg), .engStart(engStart), .engRead(engRead),
    .engCount(engCount), .engMode(engMode), .engTxWr(engTxWr),
    .engTxData(engTxData), .engRxAck(engRxAck), .engClrStop(engClrStop),
    .engClrNack(engClrNack), .engFlush(engFlush),
    .cmd(cmd), .memHi(memHi), .memLo(memLo), .addr16(addr16),
    .isRead(isRead), .segCnt(segCnt), .lastSeg(lastSeg),
    .firstSeg(firstSeg), .segOne(segOne), .remOne(remOne),
    .toExpired(toExpired), .busyExpired(busyExpired)
  );

endmodule

// File: tb/i2c_mem_seq_test.sv
module i2c_mem_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int BUSY_LIM   = 20;

  typedef struct packed {
    logic        rd;
    logic        a16;
    logic [15:0] len;
    logic [15:0] maddr;
    logic [6:0]  dev;
    logic [15:0] nackAt;
    logic [2:0]  code;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 16'd5,   16'h1234, 7'h50, 16'hFFFF, 3'd0},
    '{1'b0, 1'b0, 16'd300, 16'h00AB, 7'h51, 16'hFFFF, 3'd0},
    '{1'b1, 1'b1, 16'd7,   16'hBEEF, 7'h52, 16'hFFFF, 3'd0},
    '{1'b1, 1'b0, 16'd256, 16'h0042, 7'h53, 16'hFFFF, 3'd0},
    '{1'b0, 1'b1, 16'd10,  16'h7766, 7'h54, 16'd4,    3'd3},
    '{1'b1, 1'b0, 16'd3,   16'h0011, 7'h55, 16'd0,    3'd3},
    '{1'b0, 1'b0, 16'd1,   16'h00FE, 7'h56, 16'hFFFF, 3'd0},
    '{1'b1, 1'b1, 16'd255, 16'hA5C3, 7'h57, 16'hFFFF, 3'd0}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqAddr16 = 1'b0, reqRead = 1'b0;
  logic [6:0] reqDev = '0;
  logic [15:0] reqMemAddr = '0, reqLen = '0;
  logic [31:0] reqTimeout = '1;
  logic reqReject, doneValid, wrReady, rdValid;
  logic [2:0] doneCode;
  logic [7:0] wrData, rdData, engTxData, engCount;
  logic rdReady = 1'b1, busyForce = 1'b0, stall = 1'b0, mdlClr = 1'b0;
  logic engCfg, engStart, engRead, engTxWr, engRxAck, engClrStop, engClrNack, engFlush;
  logic [6:0] engDev;
  logic [1:0] engMode;
  logic mTxis = 0, mRxne = 0, mTcr = 0, mTc = 0, mStopf = 0, mNackf = 0, mRd = 0;
  logic [1:0] mMode = 0;
  int mCnt = 0, rxIdx = 0, wrIdx = 0, txN = 0, rdN = 0, cfgN = 0;
  int flushN = 0, clrStopN = 0, nackAt = -1, wrSeed = 0;
  logic [7:0] txLog [0:1023];
  logic [7:0] rdLog [0:1023];
  int cfgCnt [0:15];
  logic [1:0] cfgMode [0:15];
  logic cfgStart [0:15];
  logic cfgRd [0:15];
  int checkN = 0, failN = 0;

  assign wrData = 8'(wrSeed + 3 * wrIdx);
  logic [7:0] engRxData;
  assign engRxData = 8'(rxIdx) ^ 8'h5A;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_mem_seq #(.BUSY_TICKS(BUSY_LIM)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqDev(reqDev),
    .reqMemAddr(reqMemAddr), .reqAddr16(reqAddr16), .reqRead(reqRead),
    .reqLen(reqLen), .reqTimeout(reqTimeout), .reqReject(reqReject),
    .doneValid(doneValid), .doneCode(doneCode), .wrValid(1'b1),
    .wrData(wrData), .wrReady(wrReady), .rdValid(rdValid), .rdData(rdData),
    .rdReady(rdReady), .engBusy(busyForce), .engTxis(mTxis), .engRxne(mRxne),
    .engTcr(mTcr), .engTc(mTc), .engStopf(mStopf), .engNackf(mNackf),
    .engRxData(engRxData), .engCfg(engCfg), .engStart(engStart),
    .engRead(engRead), .engDev(engDev), .engCount(engCount),
    .engMode(engMode), .engTxWr(engTxWr), .engTxData(engTxData),
    .engRxAck(engRxAck), .engClrStop(engClrStop), .engClrNack(engClrNack),
    .engFlush(engFlush)
  );

  // behavioural master engine and stream sinks
  always @(posedge clk) begin
    if (mdlClr) begin
      mTxis <= 0; mRxne <= 0; mTcr <= 0; mTc <= 0; mStopf <= 0; mNackf <= 0;
      mCnt <= 0; rxIdx <= 0; wrIdx <= 0; txN <= 0; rdN <= 0; cfgN <= 0;
      flushN <= 0; clrStopN <= 0; rdReady <= 1'b1;
    end else begin
      rdReady <= ~rdReady;
      if (wrReady) wrIdx <= wrIdx + 1;
      if (rdValid && rdReady) begin rdLog[rdN] <= rdData; rdN <= rdN + 1; end
      if (engCfg) begin
        mCnt <= int'(engCount); mMode <= engMode; mRd <= engRead;
        mTcr <= 0; mTc <= 0; mTxis <= 0; mRxne <= 0;
        if (cfgN < 16) begin
          cfgCnt[cfgN] <= int'(engCount); cfgMode[cfgN] <= engMode;
          cfgStart[cfgN] <= engStart; cfgRd[cfgN] <= engRead;
        end
        cfgN <= cfgN + 1;
      end else if (engTxWr) begin
        txLog[txN] <= engTxData; txN <= txN + 1; mTxis <= 0;
        if (txN == nackAt) begin
          mNackf <= 1; mStopf <= 1; mCnt <= 0;
        end else begin
          mCnt <= mCnt - 1;
          if (mCnt == 1) begin
            if (mMode == 2'd1) mTcr <= 1;
            else if (mMode == 2'd0) mTc <= 1;
            else mStopf <= 1;
          end
        end
      end else if (engRxAck) begin
        rxIdx <= rxIdx + 1; mRxne <= 0; mCnt <= mCnt - 1;
        if (mCnt == 1) begin
          if (mMode == 2'd1) mTcr <= 1;
          else if (mMode == 2'd0) mTc <= 1;
          else mStopf <= 1;
        end
      end else begin
        mTxis <= !mRd && mCnt > 0 && !stall && !mNackf;
        mRxne <= mRd && mCnt > 0 && !stall;
      end
      if (engClrStop) begin mStopf <= 0; clrStopN <= clrStopN + 1; end
      if (engClrNack) mNackf <= 0;
      if (engFlush) flushN <= flushN + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkN++;
    if (!ok) begin
      failN++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearModel();
    @(negedge clk); mdlClr = 1'b1;
    @(negedge clk); mdlClr = 1'b0;
  endtask

  task automatic startReq(input bit rd, input bit a16, input int len,
                          input logic [15:0] ma, input logic [6:0] dv,
                          input logic [31:0] tmo);
    reqRead = rd; reqAddr16 = a16; reqLen = 16'(len); reqMemAddr = ma;
    reqDev = dv; reqTimeout = tmo; reqValid = 1'b1;
  endtask

  task automatic waitDone(output int code, output int cyc);
    cyc = 0; code = -1;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk); reqValid = 1'b0; cyc++;
      if (doneValid) begin code = int'(doneCode); break; end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failN++;
    $display("FAIL watchdog R11 actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checkN, failN);
    $finish;
  end

  initial begin
    int code, cyc, seg2, mism, ab, expMode;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!doneValid && !reqReject && !engCfg && !engTxWr && !wrReady && !rdValid &&
          !engClrStop && !engFlush, "R11 idle outputs after reset", int'(doneValid), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      clearModel();
      wrSeed = i * 16 + 1;
      nackAt = (VECS[i].nackAt == 16'hFFFF) ? -1 : int'(VECS[i].nackAt);
      startReq(VECS[i].rd, VECS[i].a16, int'(VECS[i].len), VECS[i].maddr,
               VECS[i].dev, 32'hFFFF_FFFF);
      waitDone(code, cyc);
      check(code == int'(VECS[i].code), "R5/R9 result code", code, int'(VECS[i].code));
      // address phase
      check(cfgStart[0] && !cfgRd[0] && cfgCnt[0] == (VECS[i].a16 ? 2 : 1),
            "R1 address segment count/start", cfgCnt[0], VECS[i].a16 ? 2 : 1);
      expMode = VECS[i].rd ? 0 : 1;
      check(int'(cfgMode[0]) == expMode, "R1/R3 address segment mode",
            int'(cfgMode[0]), expMode);
      if (VECS[i].a16)
        check(txLog[0] == VECS[i].maddr[15:8] && txLog[1] == VECS[i].maddr[7:0],
              "R1 location high then low", int'(txLog[0]), int'(VECS[i].maddr[15:8]));
      else
        check(txLog[0] == VECS[i].maddr[7:0], "R1 one-byte location",
              int'(txLog[0]), int'(VECS[i].maddr[7:0]));
      if (VECS[i].code == 3'd3) begin
        check(flushN == 1 && clrStopN == 1, "R9 flush and clear after no ack", flushN, 1);
        nackAt = -1;
        continue;
      end
      ab = VECS[i].a16 ? 2 : 1;
      seg2 = (VECS[i].len > 255) ? 1 : 0;
      check(cfgN == 2 + seg2, "R2 segment count", cfgN, 2 + seg2);
      check(cfgCnt[1] == ((VECS[i].len > 255) ? 255 : int'(VECS[i].len)),
            "R2 first payload count", cfgCnt[1], (VECS[i].len > 255) ? 255 : int'(VECS[i].len));
      check(int'(cfgMode[1]) == (seg2 ? 1 : 2), "R2 first payload mode",
            int'(cfgMode[1]), seg2 ? 1 : 2);
      check(cfgStart[1] == VECS[i].rd && cfgRd[1] == VECS[i].rd,
            "R3 repeated start only for read", int'(cfgStart[1]), int'(VECS[i].rd));
      if (seg2 == 1)
        check(!cfgStart[2] && cfgCnt[2] == int'(VECS[i].len) - 255 && cfgMode[2] == 2'd2,
              "R2 final segment after reload pause", cfgCnt[2], int'(VECS[i].len) - 255);
      mism = 0;
      if (VECS[i].rd) begin
        for (int k = 0; k < int'(VECS[i].len); k++)
          if (rdLog[k] != (8'(k) ^ 8'h5A)) mism++;
        check(rdN == int'(VECS[i].len) && mism == 0, "R4 read bytes in order", mism, 0);
      end else begin
        for (int k = 0; k < int'(VECS[i].len); k++)
          if (txLog[ab + k] != 8'(wrSeed + 3 * k)) mism++;
        check(txN == ab + int'(VECS[i].len) && mism == 0, "R2 write bytes in order", mism, 0);
      end
      check(clrStopN == 1, "R5 stop flag cleared once", clrStopN, 1);
    end

    // R6 zero length
    clearModel();
    startReq(1'b0, 1'b1, 0, 16'h0001, 7'h10, 32'hFFFF_FFFF);
    waitDone(code, cyc);
    check(code == 1 && cyc == 1, "R6 zero length invalid next cycle", code, 1);
    check(cfgN == 0, "R6 no engine configuration", cfgN, 0);

    // R7 request while running
    clearModel();
    wrSeed = 7;
    startReq(1'b0, 1'b0, 20, 16'h0033, 7'h11, 32'hFFFF_FFFF);
    repeat (6) begin @(negedge clk); reqValid = 1'b0; end
    reqLen = 16'd0; reqValid = 1'b1;
    @(negedge clk); reqValid = 1'b0;
    check(reqReject && !doneValid, "R7 reject while running", int'(reqReject), 1);
    waitDone(code, cyc);
    check(code == 0 && txN == 21, "R7 running transfer undisturbed", txN, 21);

    // R8 bus busy
    clearModel();
    busyForce = 1'b1;
    startReq(1'b0, 1'b0, 4, 16'h0001, 7'h12, 32'hFFFF_FFFF);
    waitDone(code, cyc);
    check(code == 2 && cfgN == 0, "R8 busy bus result", code, 2);
    check(cyc >= BUSY_LIM && cyc <= BUSY_LIM + 3, "R8 busy wait length", cyc, BUSY_LIM);
    busyForce = 1'b0;

    // R10 zero timeout
    clearModel();
    startReq(1'b0, 1'b0, 4, 16'h0001, 7'h13, 32'd0);
    waitDone(code, cyc);
    check(code == 4, "R10 zero timeout fails at once", code, 4);
    check(cyc <= 5, "R10 zero timeout latency", cyc, 4);

    // R10 timeout expiry
    clearModel();
    stall = 1'b1;
    startReq(1'b1, 1'b1, 4, 16'h0001, 7'h14, 32'd40);
    waitDone(code, cyc);
    check(code == 4 && cyc >= 40 && cyc <= 43, "R10 timeout after 40 ticks", cyc, 42);

    // R10 disabled timeout
    clearModel();
    wrSeed = 9;
    startReq(1'b0, 1'b0, 3, 16'h0005, 7'h15, 32'hFFFF_FFFF);
    code = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk); reqValid = 1'b0;
      if (doneValid) code = 1;
    end
    check(code == 0, "R10 all-ones timeout never fires", code, 0);
    stall = 1'b0;
    waitDone(code, cyc);
    check(code == 0, "R10 stalled transfer completes", code, 0);

    $display("Simulation finished: %0d checks, %0d errors", checkN, failN);
    $finish;
  end

endmodule